// File: doc/BRIEF.md
# Transceiver Control Register with Pulse Resets

This block is one 8-bit read/write configuration register on a simple microcontroller bus. It holds a few latched control fields for a line-interface transceiver. It also turns some written bits into timed reset pulses: one for a simulation-only reset, one for the transceiver and one global reset. A test-tone field keeps the transceiver in reset and switches its transmit path to a continuous tone.

Software writes the register at its single address and reads it back at any time. The reset-request bits cannot be read back: they always return 0. A global reset request puts every latched field back to its power-on value. It also clears its own request, so software never has to write the bit back to 0. Each reset request produces an output that goes high on the clock edge that takes the write and stays high for a programmable number of clocks.

Top module: `xcvr_ctrl_reg`

## Requirements
- R1: After reset, `bus_rdata` at address 0x05 reads 0x08. All pulse outputs are low, `tx_mode` is 2'b00 and only `act_dflt` is high.
- R2: A write to address 0x05 stores bit 7 in `tone_en`, bit 3 in `act_dflt`, bit 2 in `act_mode` and bit 1 in `maint_auto`. A read returns those bits in the same positions.
- R3: Bit 4 ignores writes. Bits 6, 5, 4 and 0 always read as 0.
- R4: A write with bit 5 set drives `xcvr_rst` high for exactly PULSE_W (default 4) cycles, starting at the edge that takes the write. `coef_clr` is high only in the first of those cycles.
- R5: A write with bit 6 set drives `sim_rst` high for exactly PULSE_W cycles, starting at the edge that takes the write.
- R6: While `tone_en` is 1, `xcvr_rst` is high and `tx_mode` is 2'b10 (tone). While only the bit-5 pulse is active, `tx_mode` is 2'b01 (zero level). Otherwise `tx_mode` is 2'b00 (normal).
- R7: A write with bit 0 set drives `glb_rst` high for PULSE_W cycles. At the same edge it returns all latched fields to their defaults (register value 0x08) and cancels the bit-5 and bit-6 pulses. The other bits of that write are ignored.
- R8: While `glb_rst` is high, writes have no effect.
- R9: Bus cycles to any other address, or with `bus_sel` or `bus_we` low, change nothing. Reads at other addresses return 0.
- R10: Writing bit 5 or bit 6 again while its pulse is running restarts the full PULSE_W window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus cycle select |
| bus_we | input | 1 | Write strobe (1 = write) |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| tone_en | output | 1 | Continuous test-tone enable |
| act_dflt | output | 1 | Activation default select |
| act_mode | output | 1 | ACT mode select |
| maint_auto | output | 1 | Automatic maintenance-channel enable |
| xcvr_rst | output | 1 | Transceiver held in reset |
| sim_rst | output | 1 | Simulation reset pulse |
| glb_rst | output | 1 | Global reset pulse to all other modules |
| coef_clr | output | 1 | One-cycle adaptive coefficient clear |
| tx_mode | output | 2 | Transmit source: 00 normal, 01 zero level, 10 tone |

## Verification
Two sources can hold the transceiver in reset in the same cycle: the test-tone field and the bit-5 pulse. The bench provokes this with a single write of 0xA0. It then clears the tone while the pulse is still running, and checks that `xcvr_rst` stays high until the pulse ends and that `tx_mode` falls from tone to zero level. It also writes 0x6F, which combines the global-reset request with every other request bit, and checks that the global reset wins: the fields return to default and no other pulse starts. A write made during the global reset is checked to have no effect.

// File: rtl/xcvr_ctrl_reg.sv
module xcvr_ctrl_reg #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 'h05,
  parameter int PULSE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              tone_en,
  output logic              act_dflt,
  output logic              act_mode,
  output logic              maint_auto,
  output logic              xcvr_rst,
  output logic              sim_rst,
  output logic              glb_rst,
  output logic              coef_clr,
  output logic [1:0]        tx_mode
);
  localparam int CW = $clog2(PULSE_W + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_W);
  localparam logic [3:0] FIELD_DFLT = 4'b0100;
  localparam logic [1:0] TX_NORM = 2'b00, TX_ZERO = 2'b01, TX_TONE = 2'b10;

  logic       hit, glb_req;
  logic [3:0] fld;
  logic [2:0] start, active;

  assign hit     = bus_sel && bus_we && (bus_addr == CFG_ADDR) && !glb_rst;
  assign glb_req = hit && bus_wdata[0];
  assign start   = {glb_req, hit && bus_wdata[5] && !bus_wdata[0], hit && bus_wdata[6] && !bus_wdata[0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       fld <= FIELD_DFLT;
    else if (glb_req) fld <= FIELD_DFLT;
    else if (hit)     fld <= {bus_wdata[7], bus_wdata[3:1]};

  for (genvar i = 0; i < 3; i++) begin : g_pulse
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                  cnt <= '0;
      else if (start[i])           cnt <= LOAD;
      else if (glb_req)            cnt <= '0;
      else if (cnt != '0)          cnt <= cnt - 1'b1;
    assign active[i] = (cnt != '0);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) coef_clr <= 1'b0;
    else        coef_clr <= start[1];

  assign {tone_en, act_dflt, act_mode, maint_auto} = fld;
  assign sim_rst  = active[0];
  assign glb_rst  = active[2];
  assign xcvr_rst = active[1] || tone_en;
  assign tx_mode  = tone_en ? TX_TONE : (active[1] ? TX_ZERO : TX_NORM);
  assign bus_rdata = (bus_sel && bus_addr == CFG_ADDR) ? {fld[3], 3'b000, fld[2:0], 1'b0} : 8'h00;

  a_r4_coef_in_rst: assert property (@(posedge clk) disable iff (!rst_n)
    coef_clr |-> xcvr_rst);
  a_r7_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(glb_rst) |-> (act_dflt && !tone_en && !act_mode && !maint_auto && !sim_rst));
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    glb_rst |=> $stable({tone_en, act_dflt, act_mode, maint_auto}));
  a_r5_sim_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sim_rst) |-> $past(bus_sel && bus_we && bus_wdata[6]));
  a_r3_rd_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[6:4] == 3'b000) && !bus_rdata[0]);
  if (PULSE_W > 1) begin : g_minw
    a_r4_min_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active[1]) |=> active[1]);
  end
endmodule

// File: tb/sim_xcvr_ctrl_reg.sv
`timescale 1ns/1ps
module sim_xcvr_ctrl_reg;
  localparam int PW = 4;
  typedef struct {
    logic [3:0] fld;
    logic xr, sr, gr, cc;
    logic [1:0] txm;
    string tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic tone_en, act_dflt, act_mode, maint_auto, xcvr_rst, sim_rst, glb_rst, coef_clr;
  logic [1:0] tx_mode;
  int errors = 0, checks = 0;
  exp_t q[$];
  logic [3:0] m_fld = 4'b0100;
  int u = 0, s = 0, g = 0;

  always #2 clk = ~clk;

  xcvr_ctrl_reg #(.ADDR_W(8), .CFG_ADDR(8'h05), .PULSE_W(PW)) u0 (
    .clk, .rst_n, .bus_sel, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .tone_en, .act_dflt, .act_mode, .maint_auto, .xcvr_rst, .sim_rst,
    .glb_rst, .coef_clr, .tx_mode);

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic sel, input logic we, input logic [7:0] a, input logic [7:0] d, input string tag);
    exp_t e;
    logic [7:0] rd;
    logic hit, cc;
    @(negedge clk);
    bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = d;
    #1;
    if (sel) begin
      rd = (a == 8'h05) ? {m_fld[3], 3'b000, m_fld[2:0], 1'b0} : 8'h00;
      chk(bus_rdata === rd, tag, "rdata", bus_rdata, rd);
    end
    hit = sel && we && a == 8'h05 && g == 0;
    if (u > 0) u--;
    if (s > 0) s--;
    if (g > 0) g--;
    cc = 0;
    if (hit) begin
      if (d[0]) begin m_fld = 4'b0100; u = 0; s = 0; g = PW; end
      else begin
        m_fld = {d[7], d[3:1]};
        if (d[5]) begin u = PW; cc = 1; end
        if (d[6]) s = PW;
      end
    end
    e.fld = m_fld; e.xr = (u > 0) || m_fld[3]; e.sr = s > 0; e.gr = g > 0; e.cc = cc;
    e.txm = m_fld[3] ? 2'b10 : (u > 0 ? 2'b01 : 2'b00);
    e.tag = tag;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk({tone_en, act_dflt, act_mode, maint_auto} === e.fld, e.tag, "fields",
          {tone_en, act_dflt, act_mode, maint_auto}, e.fld);
      chk(xcvr_rst === e.xr, e.tag, "xcvr_rst", xcvr_rst, e.xr);
      chk(sim_rst === e.sr, e.tag, "sim_rst", sim_rst, e.sr);
      chk(glb_rst === e.gr, e.tag, "glb_rst", glb_rst, e.gr);
      chk(coef_clr === e.cc, e.tag, "coef_clr", coef_clr, e.cc);
      chk(tx_mode === e.txm, e.tag, "tx_mode", tx_mode, e.txm);
    end
  end

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1, 0, 8'h05, 8'h00, tag);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(2, "R1 reset state");
    cyc(1, 1, 8'h05, 8'h96, "R2 R3 write fields with bit4");
    idle(2, "R2 R3 R6 readback and tone");
    cyc(1, 1, 8'h05, 8'h00, "R2 clear fields");
    cyc(1, 1, 8'h05, 8'h20, "R4 xcvr reset request");
    idle(PW + 1, "R3 R4 R6 xcvr pulse window");
    cyc(1, 1, 8'h05, 8'h40, "R5 sim reset request");
    idle(PW + 1, "R3 R5 sim pulse window");
    cyc(1, 1, 8'h05, 8'hA0, "R6 tone and xcvr reset together");
    cyc(1, 0, 8'h05, 8'h00, "R6 overlap");
    cyc(1, 1, 8'h05, 8'h00, "R6 tone off pulse running");
    idle(PW, "R6 pulse tail");
    cyc(1, 1, 8'h05, 8'h0E, "R2 set low fields");
    cyc(1, 1, 8'h05, 8'h20, "R10 first request");
    idle(2, "R10 running");
    cyc(1, 1, 8'h05, 8'h60, "R10 retrigger both");
    idle(PW + 1, "R10 full window");
    cyc(1, 1, 8'h05, 8'hE6, "R2 set fields before global");
    cyc(1, 1, 8'h05, 8'h60, "R7 start pulses");
    cyc(1, 1, 8'h05, 8'h6F, "R7 global reset wins");
    cyc(1, 1, 8'h05, 8'h86, "R8 write during global ignored");
    cyc(1, 1, 8'h05, 8'h20, "R8 reset write during global ignored");
    idle(PW, "R7 R8 global window");
    cyc(1, 1, 8'h06, 8'hFF, "R9 other address write");
    cyc(1, 0, 8'h06, 8'h00, "R9 other address read");
    cyc(0, 1, 8'h05, 8'hFF, "R9 no select");
    cyc(1, 0, 8'h05, 8'hFF, "R9 read strobe only");
    idle(2, "R9 state unchanged");
    cyc(0, 0, 8'h00, 8'h00, "R1 end");
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule